// File: doc/BRIEF.md
# Latency-Tolerant Round-Robin Crossbar Selector

This block holds the request-side and grant-side selectors of a single-iteration round-robin crossbar scheduler. Requests and grants cross a link whose round trip lasts K slots. Every input selector has one round-robin pointer per slot of that round trip, and so does every output selector. A slot counter decides which pointer set is active. Each request leaves tagged with the set that produced it, and the grant side answers it with its own pointer from that same set.

The grant outcome travels back through a K-stage delay line that stands in for the link. It returns in the slot where its set next comes up. The returning outcome moves only that set's pointers, and the request issued in that same slot already uses the moved pointers. A set is therefore never reused before its previous outcome is known. Because each set moves on its own, the pointers of a set spread out across outputs just as they would with a zero-latency link.

The VOQ buffers are outside the block. Each input presents one occupancy bit per output. A slot advances only on a cycle where `slot_en` is high.

Top module: `mps_selector`

## Requirements
- R1: After reset every request and grant pointer of every set is 0, the active set is 0, and `res_valid_o` stays 0 until K slots have passed.
- R2: `req_set_o` gives the active set. It steps 0, 1, …, K-1 and back to 0, advancing by one on each cycle with `slot_en` high.
- R3: Input i requests the first output j whose occupancy bit `voq_i[i*N+j]` is set, searching from the active set's request pointer of input i upward with wrap-around. It issues no request when all of its bits are clear. The request appears combinationally on `req_valid_o[i]` and `req_dst_o[i*W +: W]`.
- R4: Output j grants the first input that requests it, searching from the active set's grant pointer of output j upward with wrap-around.
- R5: The grant outcome of a slot appears on `res_valid_o` (bit i set when input i was granted) and `res_dst_o` exactly K slots later. `res_set_o` then equals the set of the original slot.
- R6: When an outcome arrives, a granted input's request pointer in that set becomes (granted output + 1) mod N, and the granting output's grant pointer becomes (granted input + 1) mod N. A pointer with no grant keeps its value. The request of the arrival slot already uses the new value.
- R7: An arriving outcome changes no pointer of any other set.
- R8: On a cycle with `slot_en` low, the active set, all pointers and the result outputs stay unchanged.
- R9: Within one arriving outcome, no output appears as the destination of more than one granted input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_en | input | 1 | High on cycles that end a slot |
| voq_i | input | N*N | Occupancy bit for each input/output pair; bit i*N+j is input i toward output j |
| req_valid_o | output | N | Input i issues a request in this slot |
| req_dst_o | output | N*W | Requested output for each input, W = ceil(log2 N) |
| req_set_o | output | SW | Active pointer-set ID carried with the requests |
| res_valid_o | output | N | Returning grant outcome: input i was granted |
| res_dst_o | output | N*W | Returning granted output for each input |
| res_set_o | output | SW | Pointer set the returning outcome belongs to |

## Verification
Two things always fall in the same slot. The outcome of set s arrives, and set s issues new requests that must already see the pointer moves that outcome caused. A fully occupied VOQ matrix provokes this, because it makes every pointer move on every round trip. Random gaps in `slot_en` stretch the interval between the two events. A behavioural model in the bench keeps its own pointer tables and a queue of pending outcomes. It predicts requests and outcomes every clock and compares them with the ports, so a stale or wrong-set pointer shows up as a wrong requested output in the arrival slot.

// File: rtl/mps_pkg.sv
package mps_pkg;

  // Round-robin successor of index v in a ring of n entries
  function automatic int unsigned ring_next(int unsigned v, int unsigned n);
    return (v + 1 >= n) ? 0 : v + 1;
  endfunction

endpackage

// File: rtl/mps_rr_pick.sv
module mps_rr_pick #(
  parameter int N = 4,
  parameter int W = 2
) (
  input  logic [N-1:0] req_i,
  input  logic [W-1:0] ptr_i,
  output logic         hit_o,
  output logic [W-1:0] idx_o
);

  // Scan from the highest offset down, so the smallest offset wins
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int k = N - 1; k >= 0; k--) begin
      int pos;
      pos = int'(ptr_i) + k;
      if (pos >= N) pos = pos - N;
      if (req_i[pos]) begin
        hit_o = 1'b1;
        idx_o = W'(pos);
      end
    end
  end

endmodule

// File: rtl/mps_ptr_bank.sv
module mps_ptr_bank #(
  parameter int N  = 4,
  parameter int K  = 4,
  parameter int W  = 2,
  parameter int SW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we_i,
  input  logic [SW-1:0]   set_i,
  input  logic [N*W-1:0]  wdata_i,
  output logic [N*W-1:0]  rdata_o
);

  logic [N*W-1:0] bank_q [K];

  assign rdata_o = bank_q[set_i];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < K; s++) bank_q[s] <= '0;
    end else if (we_i) begin
      bank_q[set_i] <= wdata_i;
    end
  end

endmodule

// File: rtl/mps_delay_line.sv
module mps_delay_line #(
  parameter int WD    = 8,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic [WD-1:0] d_i,
  output logic [WD-1:0] q_o
);

  logic [WD-1:0] stage_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) stage_q[k] <= '0;
    end else if (en_i) begin
      stage_q[0] <= d_i;
      for (int k = 1; k < DEPTH; k++) stage_q[k] <= stage_q[k-1];
    end
  end

  assign q_o = stage_q[DEPTH-1];

endmodule

// File: rtl/mps_selector.sv
module mps_selector #(
  parameter int N = 4,
  parameter int K = 4
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                slot_en,
  input  logic [N*N-1:0]                      voq_i,
  output logic [N-1:0]                        req_valid_o,
  output logic [N*((N > 1) ? $clog2(N) : 1)-1:0] req_dst_o,
  output logic [((K > 1) ? $clog2(K) : 1)-1:0]   req_set_o,
  output logic [N-1:0]                        res_valid_o,
  output logic [N*((N > 1) ? $clog2(N) : 1)-1:0] res_dst_o,
  output logic [((K > 1) ? $clog2(K) : 1)-1:0]   res_set_o
);
  import mps_pkg::*;

  localparam int W  = (N > 1) ? $clog2(N) : 1;
  localparam int SW = (K > 1) ? $clog2(K) : 1;
  localparam int PW = SW + N + N * W;

  // Slot counter
  logic [SW-1:0] set_q, set_d;

  always_comb begin
    set_d = set_q;
    if (slot_en) set_d = (set_q == SW'(K - 1)) ? '0 : set_q + SW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) set_q <= '0;
    else        set_q <= set_d;
  end

  // Returning outcome from the delay line
  logic [PW-1:0]  pipe_in, pipe_out;
  logic [SW-1:0]  arr_set;
  logic [N-1:0]   arr_v;
  logic [N*W-1:0] arr_dst_flat;
  logic [W-1:0]   arr_dst [N];

  assign {arr_set, arr_v, arr_dst_flat} = pipe_out;

  // Pointer storage and same-slot forwarding
  logic [N*W-1:0] r_rd_flat, g_rd_flat, r_wr_flat, g_wr_flat;
  logic [W-1:0]   r_eff [N];
  logic [W-1:0]   g_eff [N];

  always_comb begin
    for (int i = 0; i < N; i++) begin
      arr_dst[i] = arr_dst_flat[i*W +: W];
      r_eff[i]   = arr_v[i] ? W'(ring_next(int'(arr_dst[i]), N)) : r_rd_flat[i*W +: W];
    end
    for (int j = 0; j < N; j++) begin
      g_eff[j] = g_rd_flat[j*W +: W];
      for (int i = 0; i < N; i++) begin
        if (arr_v[i] && arr_dst[i] == W'(j)) g_eff[j] = W'(ring_next(i, N));
      end
    end
    for (int i = 0; i < N; i++) begin
      r_wr_flat[i*W +: W] = r_eff[i];
      g_wr_flat[i*W +: W] = g_eff[i];
    end
  end

  mps_ptr_bank #(.N(N), .K(K), .W(W), .SW(SW)) u_req_bank (
    .clk(clk), .rst_n(rst_n), .we_i(slot_en), .set_i(set_q),
    .wdata_i(r_wr_flat), .rdata_o(r_rd_flat)
  );

  mps_ptr_bank #(.N(N), .K(K), .W(W), .SW(SW)) u_gnt_bank (
    .clk(clk), .rst_n(rst_n), .we_i(slot_en), .set_i(set_q),
    .wdata_i(g_wr_flat), .rdata_o(g_rd_flat)
  );

  // Request side: one shared picker per input
  logic [N-1:0] req_v;
  logic [W-1:0] req_d [N];

  for (genvar gi = 0; gi < N; gi++) begin : g_in
    mps_rr_pick #(.N(N), .W(W)) u_pick (
      .req_i(voq_i[gi*N +: N]), .ptr_i(r_eff[gi]),
      .hit_o(req_v[gi]), .idx_o(req_d[gi])
    );
  end

  // Grant side: one shared picker per output
  logic [N-1:0] col [N];
  logic [N-1:0] out_v;
  logic [W-1:0] out_sel [N];

  always_comb begin
    for (int j = 0; j < N; j++) begin
      for (int i = 0; i < N; i++) col[j][i] = req_v[i] && (req_d[i] == W'(j));
    end
  end

  for (genvar go = 0; go < N; go++) begin : g_out
    mps_rr_pick #(.N(N), .W(W)) u_pick (
      .req_i(col[go]), .ptr_i(g_eff[go]),
      .hit_o(out_v[go]), .idx_o(out_sel[go])
    );
  end

  logic [N-1:0]   granted;
  logic [N*W-1:0] req_d_flat;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      granted[i] = 1'b0;
      for (int j = 0; j < N; j++) begin
        if (req_v[i] && req_d[i] == W'(j) && out_v[j] && out_sel[j] == W'(i)) granted[i] = 1'b1;
      end
      req_d_flat[i*W +: W] = req_d[i];
    end
  end

  // Round trip
  assign pipe_in = {set_q, granted, req_d_flat};

  mps_delay_line #(.WD(PW), .DEPTH(K)) u_link (
    .clk(clk), .rst_n(rst_n), .en_i(slot_en), .d_i(pipe_in), .q_o(pipe_out)
  );

  assign req_valid_o = req_v;
  assign req_dst_o   = req_d_flat;
  assign req_set_o   = set_q;
  assign res_valid_o = arr_v;
  assign res_dst_o   = arr_dst_flat;
  assign res_set_o   = arr_set;

endmodule

// File: rtl/mps_selector_chk.sv
module mps_selector_chk #(
  parameter int N = 4,
  parameter int K = 4
) (
  input logic                                clk,
  input logic                                rst_n,
  input logic                                slot_en,
  input logic [N*N-1:0]                      voq_i,
  input logic [N-1:0]                        req_valid_o,
  input logic [N*((N > 1) ? $clog2(N) : 1)-1:0] req_dst_o,
  input logic [((K > 1) ? $clog2(K) : 1)-1:0]   req_set_o,
  input logic [N-1:0]                        res_valid_o,
  input logic [N*((N > 1) ? $clog2(N) : 1)-1:0] res_dst_o,
  input logic [((K > 1) ? $clog2(K) : 1)-1:0]   res_set_o
);
  localparam int W  = (N > 1) ? $clog2(N) : 1;
  localparam int SW = (K > 1) ? $clog2(K) : 1;

  assert_set_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    slot_en |=> req_set_o == (($past(req_set_o) == SW'(K - 1)) ? '0 : $past(req_set_o) + SW'(1)));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_en |=> $stable(req_set_o) && $stable(res_valid_o) && $stable(res_dst_o));

  assert_res_tag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|res_valid_o) |-> res_set_o == req_set_o);

  for (genvar i = 0; i < N; i++) begin : g_req
    assert_req_has_cell_R3: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid_o[i] |-> voq_i[i*N + int'(req_dst_o[i*W +: W])]);
  end

  logic [N-1:0] res_col [N];

  always_comb begin
    for (int j = 0; j < N; j++) begin
      for (int i = 0; i < N; i++) res_col[j][i] = res_valid_o[i] && (res_dst_o[i*W +: W] == W'(j));
    end
  end

  for (genvar j = 0; j < N; j++) begin : g_res
    assert_one_per_output_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(res_col[j]));
  end

endmodule

bind mps_selector mps_selector_chk #(.N(N), .K(K)) u_chk (.*);

// File: tb/mps_selector_test.sv
module mps_selector_test;
  localparam int CLK_P = 10;
  localparam int N  = 4;
  localparam int K  = 4;
  localparam int W  = 2;
  localparam int SW = 2;
  localparam int NN = N * N;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            slot_en;
  logic [NN-1:0]   voq_i;
  logic [N-1:0]    req_valid_o, res_valid_o;
  logic [N*W-1:0]  req_dst_o, res_dst_o;
  logic [SW-1:0]   req_set_o, res_set_o;

  always #(CLK_P / 2) clk = ~clk;

  mps_selector #(.N(N), .K(K)) uut (
    .clk(clk), .rst_n(rst_n), .slot_en(slot_en), .voq_i(voq_i),
    .req_valid_o(req_valid_o), .req_dst_o(req_dst_o), .req_set_o(req_set_o),
    .res_valid_o(res_valid_o), .res_dst_o(res_dst_o), .res_set_o(res_set_o)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference
  int rp [K][N];
  int gp [K][N];
  int cur;
  int qm [$];
  int qd [$];

  always @(negedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < K; s++)
        for (int i = 0; i < N; i++) begin rp[s][i] = 0; gp[s][i] = 0; end
      cur = 0;
      qm.delete();
      qd.delete();
    end else begin
      int am, ad, effr[N], effg[N], rv[N], rd[N], gm, dpack;
      bit arr;
      arr = (qm.size() == K);
      am  = arr ? qm[0] : 0;
      ad  = arr ? qd[0] : 0;
      for (int i = 0; i < N; i++)
        effr[i] = ((am >> i) & 1) ? ((((ad >> (8*i)) & 255) + 1) % N) : rp[cur][i];
      for (int j = 0; j < N; j++) begin
        effg[j] = gp[cur][j];
        for (int i = 0; i < N; i++)
          if (((am >> i) & 1) && (((ad >> (8*i)) & 255) == j)) effg[j] = (i + 1) % N;
      end
      for (int i = 0; i < N; i++) begin
        rv[i] = 0; rd[i] = 0;
        for (int k = N - 1; k >= 0; k--) begin
          int o;
          o = (effr[i] + k) % N;
          if (voq_i[i*N + o]) begin rv[i] = 1; rd[i] = o; end
        end
      end
      gm = 0;
      for (int j = 0; j < N; j++) begin
        int win;
        win = -1;
        for (int k = N - 1; k >= 0; k--) begin
          int in;
          in = (effg[j] + k) % N;
          if (rv[in] && rd[in] == j) win = in;
        end
        if (win >= 0) gm |= (1 << win);
      end
      // Compare ports against the model
      chk(int'(req_set_o) == cur, "R2 req_set", int'(req_set_o), cur);
      for (int i = 0; i < N; i++) begin
        chk(int'(req_valid_o[i]) == rv[i], "R3 req_valid", int'(req_valid_o[i]), rv[i]);
        if (rv[i] != 0)
          chk(int'(req_dst_o[i*W +: W]) == rd[i], "R3,R6,R7 req_dst", int'(req_dst_o[i*W +: W]), rd[i]);
      end
      chk(int'(res_valid_o) == am, "R4,R5 res_valid", int'(res_valid_o), am);
      if (am != 0) begin
        int seen;
        seen = 0;
        chk(int'(res_set_o) == cur, "R5 res_set", int'(res_set_o), cur);
        for (int i = 0; i < N; i++) if ((am >> i) & 1) begin
          int d;
          d = (ad >> (8*i)) & 255;
          chk(int'(res_dst_o[i*W +: W]) == d, "R5 res_dst", int'(res_dst_o[i*W +: W]), d);
          chk(((seen >> int'(res_dst_o[i*W +: W])) & 1) == 0, "R9 duplicate output", int'(res_dst_o[i*W +: W]), -1);
          seen |= (1 << int'(res_dst_o[i*W +: W]));
        end
      end
      // Commit the slot
      if (slot_en) begin
        for (int i = 0; i < N; i++) begin rp[cur][i] = effr[i]; gp[cur][i] = effg[i]; end
        if (arr) begin void'(qm.pop_front()); void'(qd.pop_front()); end
        dpack = 0;
        for (int i = 0; i < N; i++) dpack |= (rd[i] << (8*i));
        qm.push_back(gm);
        qd.push_back(dpack);
        cur = (cur + 1) % K;
      end
    end
  end

  task automatic step(input int n);
    for (int c = 0; c < n; c++) begin
      @(posedge clk);
      #1;
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n   = 1'b0;
    slot_en = 1'b0;
    voq_i   = '0;
    step(3);
    voq_i   = '1;
    slot_en = 1'b1;
    rst_n   = 1'b1;
    // R1: first slot after reset uses zeroed pointers and has no returning outcome
    @(negedge clk);
    chk(req_set_o == '0, "R1 set after reset", int'(req_set_o), 0);
    chk(res_valid_o == '0, "R1 no outcome after reset", int'(res_valid_o), 0);
    for (int i = 0; i < N; i++)
      chk(req_dst_o[i*W +: W] == '0, "R1 pointer after reset", int'(req_dst_o[i*W +: W]), 0);
    for (int s = 1; s < K; s++) begin
      @(negedge clk);
      chk(res_valid_o == '0, "R1 no outcome before K slots", int'(res_valid_o), 0);
    end
    step(40);
    // Random occupancy with slot gaps
    for (int c = 0; c < 300; c++) begin
      voq_i   = NN'($urandom);
      slot_en = ($urandom % 10) < 7;
      step(1);
    end
    // Every input contends for output 2 (R4)
    slot_en = 1'b1;
    voq_i = '0;
    for (int i = 0; i < N; i++) voq_i[i*N + 2] = 1'b1;
    step(40);
    voq_i = '0;
    step(12);
    // Slot hold with changing occupancy (R8)
    voq_i = '1;
    step(9);
    slot_en = 1'b0;
    begin
      logic [SW-1:0] held_set;
      logic [N-1:0]  held_res;
      @(negedge clk);
      held_set = req_set_o;
      held_res = res_valid_o;
      for (int c = 0; c < 10; c++) begin
        step(1);
        voq_i = NN'($urandom);
        @(negedge clk);
        chk(req_set_o == held_set, "R8 set held", int'(req_set_o), int'(held_set));
        chk(res_valid_o == held_res, "R8 outcome held", int'(res_valid_o), int'(held_res));
      end
    end
    step(1);
    slot_en = 1'b1;
    // Sparse random occupancy
    for (int c = 0; c < 300; c++) begin
      voq_i   = NN'($urandom & $urandom);
      slot_en = ($urandom % 8) != 0;
      step(1);
    end
    step(2);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule